// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This unit takes two IEEE-754 operands, either single precision (held in the low 32 bits of each 64-bit operand port) or double precision. It evaluates one of five operations: equal, greater-than, greater-or-equal, minimum or maximum. Compares are always quiet: an unordered pair gives a false predicate and never touches the exception state. Minimum and maximum ignore a single NaN and return the other operand. When both operands are NaN they return an all-ones pattern. Only a double-precision min/max that sees a signalling NaN raises the invalid flag.

The unit keeps a five-bit sticky exception register. Each valid operation ORs its computed flags into the register. The register changes in no other way, except through an explicit software write that replaces its contents. Results can be registered (one cycle of latency, the default) or combinational. The choice is made with a parameter.

Top module: `fp_cmpmm_unit`

## Requirements
- R1: With `op_sel` 0 = equal, 1 = greater-than, 2 = greater-or-equal, and neither operand NaN, the predicate follows signed IEEE ordering of A against B, and -0 equals +0.
- R2: A compare in which either operand is NaN gives a false predicate. A NaN is an all-ones exponent with a nonzero fraction.
- R3: A compare never changes the exception register.
- R4: `pred` is 8'hFF for true and 8'h00 for false. Min/max and unused opcodes give 8'h00. Compares drive `result` to zero.
- R5: With `op_sel` 3 = minimum and 4 = maximum and ordered operands, the smaller or larger operand is returned. When the operands compare equal (including ±0), operand A is returned.
- R6: If exactly one min/max operand is NaN, the result is the other operand. Single-precision results are zero-extended into the 64-bit port.
- R7: If both min/max operands are NaN, the result is 64'h00000000_FFFFFFFF for single precision (`prec_dbl` = 0) and all 64 ones for double precision (`prec_dbl` = 1).
- R8: Invalid is raised only by a double-precision min/max with a signalling NaN input, that is, a NaN whose fraction MSB is 0. Quiet NaNs and all single-precision inputs raise no flag.
- R9: The flag vector holds invalid at bit 1, divide-by-zero at bit 2, overflow at bit 3, underflow at bit 4 and inexact at bit 5. Bits are sticky: `flag_wr` loads `flag_wdata`, and the computed flags of an operation in the same cycle are ORed on top.
- R10: After reset, `out_valid`, `result`, `pred` and the flags are zero. With `REG_OUT` = 1, the outputs for an operation appear one cycle after `in_valid`, qualified by `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| prec_dbl | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| op_sel | input | 3 | 0 eq, 1 gt, 2 ge, 3 min, 4 max |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| flag_wr | input | 1 | Software write of the flag register |
| flag_wdata | input | 5 | Value written, bits [5:1] |
| out_valid | output | 1 | Result qualifier |
| result | output | 64 | Min/max value, zero for compares |
| pred | output | 8 | Replicated compare predicate |
| stat_flags | output | 5 | Sticky exception flags, bits [5:1] |

## Verification
The checker observes, on every cycle, the following properties:
- the predicate is always one of its two legal forms;
- an unordered compare yields false;
- two NaN operands to min/max yield the all-ones pattern for the selected precision;
- compares leave the flags unchanged;
- without a write, no flag bit ever clears;
- bits 2 to 5 move only on a write.

The bench scenarios cover the following behaviours:
- signed ordering, including negative operands and ±0;
- selection of the non-NaN operand;
- the first-operand choice on ties;
- the quiet-versus-signalling split between the two precisions;
- a write that clears or presets the flags before further accumulation.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;
  localparam int DATA_W    = 64;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int MAG_W     = DATA_W - 1;
  localparam int FLAG_LO   = 1;
  localparam int FLAG_HI   = 5;
  localparam int FLG_INV   = 1;
  localparam int PRED_W    = 8;

  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_GT  = 3'd1,
    OP_GE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4
  } op_e;

  typedef struct packed {
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } opnd_info_t;
endpackage

// File: rtl/fpcm_classify.sv
module fpcm_classify
  import fpcm_pkg::*;
(
  input  logic              dbl,
  input  logic [DATA_W-1:0] opnd,
  output opnd_info_t        info
);
  localparam int SP_QBIT = SP_FRAC_W - 1;
  localparam int DP_QBIT = DP_FRAC_W - 1;

  logic exp_ones, frac_nz, qbit;

  always_comb begin
    if (dbl) begin
      exp_ones  = &opnd[DATA_W-2 -: DP_EXP_W];
      frac_nz   = |opnd[DP_FRAC_W-1:0];
      qbit      = opnd[DP_QBIT];
      info.sign = opnd[DATA_W-1];
      info.mag  = opnd[MAG_W-1:0];
    end else begin
      exp_ones  = &opnd[SP_W-2 -: SP_EXP_W];
      frac_nz   = |opnd[SP_FRAC_W-1:0];
      qbit      = opnd[SP_QBIT];
      info.sign = opnd[SP_W-1];
      info.mag  = {{(MAG_W-SP_W+1){1'b0}}, opnd[SP_W-2:0]};
    end
    info.is_nan  = exp_ones && frac_nz;
    info.is_snan = exp_ones && frac_nz && !qbit;
    info.is_zero = (info.mag == '0);
  end
endmodule

// File: rtl/fpcm_order.sv
module fpcm_order
  import fpcm_pkg::*;
(
  input  opnd_info_t a,
  input  opnd_info_t b,
  output logic       a_eq_b,
  output logic       a_gt_b
);
  always_comb begin
    a_eq_b = (a.is_zero && b.is_zero) || (a.sign == b.sign && a.mag == b.mag);
    if (a_eq_b)               a_gt_b = 1'b0;
    else if (a.sign != b.sign) a_gt_b = !a.sign;
    else if (!a.sign)          a_gt_b = (a.mag > b.mag);
    else                       a_gt_b = (a.mag < b.mag);
  end
endmodule

// File: rtl/fpcm_flags.sv
module fpcm_flags
  import fpcm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [FLAG_HI:FLAG_LO] wdata,
  input  logic [FLAG_HI:FLAG_LO] set_bits,
  output logic [FLAG_HI:FLAG_LO] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (wr ? wdata : flags) | set_bits;
  end
endmodule

// File: rtl/fp_cmpmm_unit.sv
module fp_cmpmm_unit
  import fpcm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   prec_dbl,
  input  logic [2:0]             op_sel,
  input  logic [DATA_W-1:0]      opnd_a,
  input  logic [DATA_W-1:0]      opnd_b,
  input  logic                   flag_wr,
  input  logic [FLAG_HI:FLAG_LO] flag_wdata,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      result,
  output logic [PRED_W-1:0]      pred,
  output logic [FLAG_HI:FLAG_LO] stat_flags
);
  localparam int NOPND = 2;

  logic [DATA_W-1:0] opnd_v [NOPND];
  opnd_info_t        info_v [NOPND];
  assign opnd_v[0] = opnd_a;
  assign opnd_v[1] = opnd_b;

  for (genvar i = 0; i < NOPND; i++) begin : g_cls
    fpcm_classify u_cls (.dbl(prec_dbl), .opnd(opnd_v[i]), .info(info_v[i]));
  end

  logic a_eq_b, a_gt_b;
  fpcm_order u_ord (.a(info_v[0]), .b(info_v[1]), .a_eq_b(a_eq_b), .a_gt_b(a_gt_b));

  logic [DATA_W-1:0] a_ext, b_ext, all_ones;
  assign a_ext    = prec_dbl ? opnd_a : {{(DATA_W-SP_W){1'b0}}, opnd_a[SP_W-1:0]};
  assign b_ext    = prec_dbl ? opnd_b : {{(DATA_W-SP_W){1'b0}}, opnd_b[SP_W-1:0]};
  assign all_ones = prec_dbl ? '1 : {{(DATA_W-SP_W){1'b0}}, {SP_W{1'b1}}};

  logic                   any_nan, both_nan, cmp_true, is_mm;
  logic [DATA_W-1:0]      res_c;
  logic [PRED_W-1:0]      pred_c;
  logic [FLAG_HI:FLAG_LO] set_c;

  always_comb begin
    any_nan  = info_v[0].is_nan || info_v[1].is_nan;
    both_nan = info_v[0].is_nan && info_v[1].is_nan;
    cmp_true = 1'b0;
    is_mm    = 1'b0;
    res_c    = '0;
    case (op_e'(op_sel))
      OP_EQ:  cmp_true = !any_nan && a_eq_b;
      OP_GT:  cmp_true = !any_nan && a_gt_b;
      OP_GE:  cmp_true = !any_nan && (a_gt_b || a_eq_b);
      OP_MIN: begin
        is_mm = 1'b1;
        if (both_nan)               res_c = all_ones;
        else if (info_v[0].is_nan)  res_c = b_ext;
        else if (info_v[1].is_nan)  res_c = a_ext;
        else                        res_c = a_gt_b ? b_ext : a_ext;
      end
      OP_MAX: begin
        is_mm = 1'b1;
        if (both_nan)               res_c = all_ones;
        else if (info_v[0].is_nan)  res_c = b_ext;
        else if (info_v[1].is_nan)  res_c = a_ext;
        else                        res_c = (a_gt_b || a_eq_b) ? a_ext : b_ext;
      end
      default: ;
    endcase
    pred_c = {PRED_W{cmp_true}};
    set_c  = '0;
    set_c[FLG_INV] = in_valid && is_mm && prec_dbl &&
                     (info_v[0].is_snan || info_v[1].is_snan);
  end

  fpcm_flags u_flg (
    .clk(clk), .rst(rst), .wr(flag_wr), .wdata(flag_wdata),
    .set_bits(set_c), .flags(stat_flags)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        pred      <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result <= res_c;
          pred   <= pred_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_c;
    assign pred      = pred_c;
  end
endmodule

// File: rtl/fpcm_chk.sv
module fpcm_chk
  import fpcm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   prec_dbl,
  input logic [2:0]             op_sel,
  input logic [DATA_W-1:0]      opnd_a,
  input logic [DATA_W-1:0]      opnd_b,
  input logic                   flag_wr,
  input logic [FLAG_HI:FLAG_LO] flag_wdata,
  input logic                   out_valid,
  input logic [DATA_W-1:0]      result,
  input logic [PRED_W-1:0]      pred,
  input logic [FLAG_HI:FLAG_LO] stat_flags
);
  function automatic logic nan_of(input logic dbl, input logic [DATA_W-1:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
    return (x[30:23] == 8'hFF) && (x[22:0] != '0);
  endfunction

  logic is_cmp, is_mm, a_nan, b_nan;
  assign is_cmp = (op_sel <= 3'd2);
  assign is_mm  = (op_sel == 3'd3) || (op_sel == 3'd4);
  assign a_nan  = nan_of(prec_dbl, opnd_a);
  assign b_nan  = nan_of(prec_dbl, opnd_b);

  // R4: predicate is only ever all-zero or all-one
  a_r4_pred_form: assert property (@(posedge clk) disable iff (rst)
    (pred == '0) || (pred == '1));

  // R3: a compare leaves the flags untouched
  a_r3_cmp_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp && !flag_wr) |=> (stat_flags == $past(stat_flags)));

  // R9: no flag clears without a write
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> (($past(stat_flags) & ~stat_flags) == '0));

  // R8: only invalid can be raised by an operation
  a_r8_only_invalid: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> (stat_flags[FLAG_HI:FLAG_LO+1] == $past(stat_flags[FLAG_HI:FLAG_LO+1])));

  if (REG_OUT) begin : g_out
    // R2: unordered compare is false
    a_r2_nan_false: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_cmp && (a_nan || b_nan)) |=> (pred == '0));

    // R7: two NaNs give all ones of the chosen width
    a_r7_both_nan: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_mm && a_nan && b_nan) |=>
        (result == ($past(prec_dbl) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF)));

    // R10: out_valid follows in_valid by one cycle
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
  end
endmodule

bind fp_cmpmm_unit fpcm_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .prec_dbl(prec_dbl),
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_wr(flag_wr),
  .flag_wdata(flag_wdata), .out_valid(out_valid), .result(result),
  .pred(pred), .stat_flags(stat_flags)
);

// File: tb/fp_cmpmm_unit_tb_top.sv
module fp_cmpmm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        prec_dbl = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        flag_wr = 1'b0;
  logic [5:1]  flag_wdata = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  pred;
  logic [5:1]  stat_flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] q_res [$];
  logic [7:0]  q_pred [$];
  string       q_tag [$];

  always #10 clk = ~clk;

  fp_cmpmm_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .prec_dbl(prec_dbl),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .out_valid(out_valid), .result(result),
    .pred(pred), .stat_flags(stat_flags)
  );

  localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000, SM1 = 64'hBF800000,
                          SM2 = 64'hC0000000, SZ = 64'h0, SNZ = 64'h80000000,
                          SQN = 64'h7FC00000, SSN = 64'h7F800001, SONES = 64'hFFFFFFFF;
  localparam logic [63:0] D1 = 64'h3FF0000000000000, DM2 = 64'hC000000000000000,
                          DANY = 64'h3F80000000000000, DQN = 64'h7FF8000000000000,
                          DSN = 64'h7FF7000000000000, DONES = '1;

  task automatic op(input bit dbl, input logic [2:0] o, input logic [63:0] a,
                    input logic [63:0] b, input logic [63:0] er,
                    input logic [7:0] ep, input string tag);
    @(negedge clk);
    prec_dbl = dbl; op_sel = o; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    q_res.push_back(er); q_pred.push_back(ep); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr_flags(input logic [5:1] v);
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic chk_flags(input logic [5:1] exp, input string tag);
    @(negedge clk);
    total++;
    if (stat_flags !== exp) begin
      bad++;
      $display("FAIL %s flags actual=%b expected=%b", tag, stat_flags, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected out_valid actual=1 expected=0");
      end else begin
        logic [63:0] er;
        logic [7:0]  ep;
        string       t;
        er = q_res.pop_front(); ep = q_pred.pop_front(); t = q_tag.pop_front();
        total++;
        if (result !== er || pred !== ep) begin
          bad++;
          $display("FAIL %s actual=%h/%h expected=%h/%h", t, result, pred, er, ep);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0 || pred !== '0 || stat_flags !== '0) begin
      bad++;
      $display("FAIL R10 reset actual=%b/%h/%h/%b expected=0", out_valid, result, pred, stat_flags);
    end
    // R1 ordered compares
    op(0, 3'd0, S1,  S1,  '0, 8'hFF, "R1 eq 1,1");
    op(0, 3'd1, S2,  S1,  '0, 8'hFF, "R1 gt 2,1");
    op(0, 3'd1, S1,  S2,  '0, 8'h00, "R1 gt 1,2");
    op(0, 3'd2, SM1, SM1, '0, 8'hFF, "R1 ge -1,-1");
    op(0, 3'd1, SM1, SM2, '0, 8'hFF, "R1 gt -1,-2");
    op(0, 3'd0, SZ,  SNZ, '0, 8'hFF, "R1 eq +0,-0");
    op(1, 3'd1, DM2, D1,  '0, 8'h00, "R1 gt dp -2,1");
    // R2/R3 quiet unordered compares
    op(0, 3'd0, SQN, S1,   '0, 8'h00, "R2 eq nan");
    op(0, 3'd1, SQN, S1,   '0, 8'h00, "R2 gt nan");
    op(0, 3'd2, S1,  SSN,  '0, 8'h00, "R2 ge snan");
    op(1, 3'd1, DQN, DANY, '0, 8'h00, "R2 gt dp qnan");
    op(1, 3'd2, DSN, DANY, '0, 8'h00, "R2 ge dp snan");
    chk_flags(5'b00000, "R3 compares raise nothing");
    // R4 unused opcode
    op(0, 3'd6, S1, S2, '0, 8'h00, "R4 unused op");
    // R5 ordered min/max
    op(0, 3'd3, S2,  S1,  S1,  8'h00, "R5 min 2,1");
    op(0, 3'd4, SM1, S2,  S2,  8'h00, "R5 max -1,2");
    op(0, 3'd3, SZ,  SNZ, SZ,  8'h00, "R5 min +0,-0 first");
    op(0, 3'd3, SNZ, SZ,  SNZ, 8'h00, "R5 min -0,+0 first");
    op(1, 3'd3, DM2, D1,  DM2, 8'h00, "R5 dp min -2,1");
    // R6 one NaN
    op(0, 3'd3, SQN, S1,   S1,   8'h00, "R6 min qnan,1");
    op(0, 3'd4, S1,  SQN,  S1,   8'h00, "R6 max 1,qnan");
    op(0, 3'd3, SSN, S1,   S1,   8'h00, "R6 sp min snan,1");
    op(1, 3'd3, DQN, DANY, DANY, 8'h00, "R6 dp min qnan");
    // R7 both NaN
    op(0, 3'd3, SQN, SQN, SONES, 8'h00, "R7 sp both nan");
    op(1, 3'd4, DQN, DQN, DONES, 8'h00, "R7 dp both qnan");
    chk_flags(5'b00000, "R8 quiet and sp nans raise nothing");
    // R8 dp signalling
    op(1, 3'd3, DSN, DANY, DANY, 8'h00, "R8 dp min snan");
    chk_flags(5'b00001, "R8 invalid at bit 1");
    op(1, 3'd4, DQN, DANY, DANY, 8'h00, "R9 sticky op");
    chk_flags(5'b00001, "R9 invalid stays set");
    wr_flags(5'b00000);
    chk_flags(5'b00000, "R9 write clears");
    wr_flags(5'b10100);
    chk_flags(5'b10100, "R9 write loads");
    op(1, 3'd4, DSN, DSN, DONES, 8'h00, "R7 dp both snan");
    chk_flags(5'b10101, "R9 accumulate over written bits");
    repeat (3) @(negedge clk);
    total++;
    if (q_res.size() != 0) begin
      bad++;
      $display("FAIL R10 missing results actual=%0d expected=0", q_res.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule